// File: doc/BRIEF.md
# SDRAM Address Mapper and Row Tracker

This block sits between a host that issues linear byte addresses and the command engine of an SDRAM controller. It splits each host address into bank, row and column fields and remembers which row is open in every bank. For each access it emits the shortest command sequence that reaches the data: a read or write alone on a row hit, or an activate first, with a precharge in front of it when another row is in the way. The command engine receives the commands through a valid/ready port. The block does not handle refresh timing, mode programming, data timing or the pins.

The layout is set at runtime. The column width can be 8 to 11 bits and the bank count can be 1, 2, 4 or 8. The row width can be 11 to 13 bits. Two orders for the fields are supported. The interleaved order moves to the next bank each time the column field wraps. The contiguous order fills one bank completely before it moves to the next, and it keeps at most one bank open at any time. A precharge-all input closes every bank, for example before a refresh.

Top module: `sdram_addr_mapper`

## Requirements
- R1: The low two address bits are a byte offset and are dropped. The rest is the word address W. With C = 2^(8+cfg_col_bits), B = 2^cfg_bank_sel and R = 2^(11+cfg_row_bits), a cfg_row_bits value of 3 acts as 2. In interleaved order (cfg_mode=0) the fields are col = W mod C, bank = (W/C) mod B and row = (W/(C·B)) mod R.
- R2: In contiguous order (cfg_mode=1) the fields are col = W mod C, row = (W/C) mod R and bank = (W/(C·R)) mod B.
- R3: An address at or beyond C·B·R words wraps. It maps to the same bank, row and column as the address reduced modulo that capacity.
- R4: An access to a closed bank produces an activate (code 0) with the bank and row, then a read (code 1) or write (code 2) with the bank and column.
- R5: In interleaved order, an access to a bank whose open row differs produces a precharge (code 3) for that bank, then an activate, then the read or write.
- R6: A row hit produces only the read or write. In contiguous order, a hit also needs every other bank to be closed.
- R7: In contiguous order, a miss while any bank is open produces a precharge-all (code 4), then an activate, then the read or write. No activate is issued while any bank is still open.
- R8: A one-cycle pulse on pa_req produces exactly one precharge-all command and closes every bank. The next access to any bank therefore starts with an activate.
- R9: Each command is issued in one valid/ready handshake. Its code and fields stay stable while it is stalled. req_ready is high only when no command is pending, and no command follows the final read or write of a request.
- R10: Configuration inputs are used only when a request is accepted. Changing them while the request's commands are in flight has no effect on those commands.
- R11: After reset, req_ready is 1, cmd_valid is 0 and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_col_bits | input | 2 | Column width minus 8 |
| cfg_bank_sel | input | 2 | log2 of the bank count |
| cfg_row_bits | input | 2 | Row width minus 11 (3 acts as 2) |
| cfg_mode | input | 1 | 0 interleaved order, 1 contiguous order |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Linear byte address |
| req_write | input | 1 | 1 write, 0 read |
| pa_req | input | 1 | Pulse requesting a precharge of all banks |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command taken when high with cmd_valid |
| cmd_code | output | 3 | 0 activate, 1 read, 2 write, 3 precharge, 4 precharge-all |
| cmd_bank | output | BANK_W | Bank for the command |
| cmd_row | output | ROW_W | Row for an activate |
| cmd_col | output | COL_W | Column for a read or write |

## Verification
Contiguous order with several banks open is the hardest case to reach. It arises only when rows were opened under interleaved order and the mode is switched without a flush. The bench builds that case on purpose. It opens two banks in interleaved order, changes cfg_mode, and then hits one of the open rows. The expected result is a precharge-all rather than a bare read. Configuration scrambling is also hard to reach, because it must land inside a command sequence. The bench therefore scrambles every config input right after a request is accepted and holds the scrambled values while the commands are collected under random back-pressure.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [2:0] {
    CMD_ACT  = 3'd0,
    CMD_RD   = 3'd1,
    CMD_WR   = 3'd2,
    CMD_PRE  = 3'd3,
    CMD_PREA = 3'd4
  } sam_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PREA,
    ST_ACT,
    ST_RW,
    ST_FLUSH
  } sam_state_e;
endpackage

// File: rtl/sam_addr_split.sv
module sam_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 11,
  parameter int COL_MIN = 8,
  parameter int ROW_MIN = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cfg_col_bits,
  input  logic [1:0]        cfg_bank_sel,
  input  logic [1:0]        cfg_row_bits,
  input  logic              cfg_mode,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  localparam int WORD_W = ADDR_W - 2;

  function automatic logic [WORD_W-1:0] low_mask(input int n);
    if (n >= WORD_W) return '1;
    return (WORD_W'(1) << n) - WORD_W'(1);
  endfunction

  function automatic int row_width(input logic [1:0] sel);
    return ROW_MIN + ((sel > 2'd2) ? 2 : int'(sel));
  endfunction

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] col_w, bank_w, row_w;
  int cb, bb, rb;

  always_comb begin
    word = addr[ADDR_W-1:2];
    cb   = COL_MIN + int'(cfg_col_bits);
    bb   = int'(cfg_bank_sel);
    rb   = row_width(cfg_row_bits);
    col_w = word & low_mask(cb);
    if (!cfg_mode) begin
      bank_w = (word >> cb) & low_mask(bb);
      row_w  = (word >> (cb + bb)) & low_mask(rb);
    end else begin
      row_w  = (word >> cb) & low_mask(rb);
      bank_w = (word >> (cb + rb)) & low_mask(bb);
    end
  end

  assign bank = bank_w[BANK_W-1:0];
  assign row  = row_w[ROW_W-1:0];
  assign col  = col_w[COL_W-1:0];
endmodule

// File: rtl/sam_open_rows.sv
module sam_open_rows #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 13,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic [BANK_W-1:0]           set_bank,
  input  logic [ROW_W-1:0]            set_row,
  input  logic                        clr_en,
  input  logic [BANK_W-1:0]           clr_bank,
  input  logic                        clr_all,
  output logic [BANKS-1:0]            open_vld,
  output logic [BANKS-1:0][ROW_W-1:0] open_row
);
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vld[g] <= 1'b0;
        open_row[g] <= '0;
      end else if (clr_all) begin
        open_vld[g] <= 1'b0;
      end else if (clr_en && clr_bank == BANK_W'(g)) begin
        open_vld[g] <= 1'b0;
      end else if (set_en && set_bank == BANK_W'(g)) begin
        open_vld[g] <= 1'b1;
        open_row[g] <= set_row;
      end
    end
  end
endmodule

// File: rtl/sam_cmd_seq.sv
module sam_cmd_seq
  import sam_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [BANK_W-1:0]           dec_bank,
  input  logic [ROW_W-1:0]            dec_row,
  input  logic [COL_W-1:0]            dec_col,
  input  logic                        cfg_mode,
  input  logic                        pa_req,
  input  logic                        cmd_ready,
  input  logic [BANKS-1:0]            open_vld,
  input  logic [BANKS-1:0][ROW_W-1:0] open_row,
  output logic                        req_ready,
  output logic                        cmd_valid,
  output logic [2:0]                  cmd_code,
  output logic [BANK_W-1:0]           cmd_bank,
  output logic [ROW_W-1:0]            cmd_row,
  output logic [COL_W-1:0]            cmd_col,
  output logic                        tbl_set,
  output logic                        tbl_clr,
  output logic                        tbl_clr_all,
  output logic                        acc_fire,
  output logic                        cmd_fire,
  output logic                        row_hit,
  output logic                        mode_q
);
  sam_state_e state, first_state;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q, pa_pend;
  logic              tgt_open, others_open, any_open;
  sam_cmd_e          code_e;

  assign tgt_open    = open_vld[dec_bank];
  assign others_open = |(open_vld & ~(BANKS'(1) << dec_bank));
  assign any_open    = |open_vld;
  assign row_hit     = tgt_open && (open_row[dec_bank] == dec_row) && !(cfg_mode && others_open);

  always_comb begin
    if (row_hit)       first_state = ST_RW;
    else if (cfg_mode) first_state = any_open ? ST_PREA : ST_ACT;
    else               first_state = tgt_open ? ST_PRE : ST_ACT;
  end

  assign req_ready = (state == ST_IDLE) && !pa_pend;
  assign acc_fire  = req_valid && req_ready;
  assign cmd_valid = (state != ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pa_pend <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      if (pa_req) pa_pend <= 1'b1;
      else if (state == ST_IDLE && pa_pend) pa_pend <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (pa_pend) state <= ST_FLUSH;
          else if (acc_fire) begin
            state  <= first_state;
            bank_q <= dec_bank;
            row_q  <= dec_row;
            col_q  <= dec_col;
            wr_q   <= req_write;
            mode_q <= cfg_mode;
          end
        end
        ST_PRE, ST_PREA: if (cmd_ready) state <= ST_ACT;
        ST_ACT:          if (cmd_ready) state <= ST_RW;
        ST_RW, ST_FLUSH: if (cmd_ready) state <= ST_IDLE;
        default:         state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_PRE:            code_e = CMD_PRE;
      ST_PREA, ST_FLUSH: code_e = CMD_PREA;
      ST_RW:             code_e = wr_q ? CMD_WR : CMD_RD;
      default:           code_e = CMD_ACT;
    endcase
  end

  assign cmd_code = code_e;
  assign cmd_bank = bank_q;
  assign cmd_row  = row_q;
  assign cmd_col  = col_q;

  assign tbl_set     = cmd_fire && (state == ST_ACT);
  assign tbl_clr     = cmd_fire && (state == ST_PRE);
  assign tbl_clr_all = cmd_fire && (state == ST_PREA || state == ST_FLUSH);
endmodule

// File: rtl/sdram_addr_mapper.sv
module sdram_addr_mapper #(
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 11,
  parameter int COL_MIN = 8,
  parameter int ROW_MIN = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_col_bits,
  input  logic [1:0]        cfg_bank_sel,
  input  logic [1:0]        cfg_row_bits,
  input  logic              cfg_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              pa_req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  localparam int BANKS = 1 << BANK_W;

  logic [BANK_W-1:0]           dec_bank;
  logic [ROW_W-1:0]            dec_row;
  logic [COL_W-1:0]            dec_col;
  logic [BANKS-1:0]            open_vld;
  logic [BANKS-1:0][ROW_W-1:0] open_row;
  logic tbl_set, tbl_clr, tbl_clr_all;
  logic acc_fire, cmd_fire, row_hit, mode_q;

  sam_addr_split #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .COL_MIN(COL_MIN), .ROW_MIN(ROW_MIN)
  ) split_i (
    .addr(req_addr), .cfg_col_bits(cfg_col_bits), .cfg_bank_sel(cfg_bank_sel),
    .cfg_row_bits(cfg_row_bits), .cfg_mode(cfg_mode),
    .bank(dec_bank), .row(dec_row), .col(dec_col)
  );

  sam_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) rows_i (
    .clk(clk), .rst_n(rst_n),
    .set_en(tbl_set), .set_bank(cmd_bank), .set_row(cmd_row),
    .clr_en(tbl_clr), .clr_bank(cmd_bank), .clr_all(tbl_clr_all),
    .open_vld(open_vld), .open_row(open_row)
  );

  sam_cmd_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .dec_bank(dec_bank), .dec_row(dec_row), .dec_col(dec_col),
    .cfg_mode(cfg_mode), .pa_req(pa_req), .cmd_ready(cmd_ready),
    .open_vld(open_vld), .open_row(open_row),
    .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .tbl_set(tbl_set), .tbl_clr(tbl_clr), .tbl_clr_all(tbl_clr_all),
    .acc_fire(acc_fire), .cmd_fire(cmd_fire), .row_hit(row_hit), .mode_q(mode_q)
  );
endmodule

// File: rtl/sam_checker.sv
module sam_checker
  import sam_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [COL_W-1:0]  cmd_col,
  input logic              cmd_fire,
  input logic [BANKS-1:0]  open_vld,
  input logic              mode_q
);
  logic is_rw;
  assign is_rw = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_bank)
      && $stable(cmd_row) && $stable(cmd_col));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  assert_rw_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && is_rw |=> !cmd_valid);

  assert_pre_then_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_code == CMD_PRE |=> cmd_valid && cmd_code == CMD_ACT && $stable(cmd_bank));

  assert_act_then_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_code == CMD_ACT |=> cmd_valid && is_rw && $stable(cmd_bank));

  assert_single_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_code == CMD_ACT && mode_q |-> open_vld == '0);

  assert_prea_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_code == CMD_PREA |=> open_vld == '0);
endmodule

bind sdram_addr_mapper sam_checker #(
  .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
  .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_fire(cmd_fire),
  .open_vld(open_vld), .mode_q(mode_q)
);

// File: tb/sdram_addr_mapper_tb_top.sv
module sdram_addr_mapper_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_col_bits = '0, cfg_bank_sel = '0, cfg_row_bits = '0;
  logic cfg_mode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pa_req = 1'b0, cmd_ready = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_ready, cmd_valid;
  logic [2:0] cmd_code, cmd_bank;
  logic [12:0] cmd_row;
  logic [10:0] cmd_col;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_vld[8];
  int m_row[8];
  int c_cb, c_bs, c_rb, c_md;

  always #5 clk = ~clk;

  sdram_addr_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_col_bits(cfg_col_bits), .cfg_bank_sel(cfg_bank_sel),
    .cfg_row_bits(cfg_row_bits), .cfg_mode(cfg_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write), .pa_req(pa_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_cfg(int md, int cb, int bs, int rb);
    c_md = md; c_cb = cb; c_bs = bs; c_rb = rb;
    cfg_mode = md[0]; cfg_col_bits = cb[1:0]; cfg_bank_sel = bs[1:0]; cfg_row_bits = rb[1:0];
  endtask

  task automatic take_cmd(output int code, output int bank, output int row, output int col);
    do begin
      @(negedge clk);
      cmd_ready = ($urandom % 3) != 0;
    end while (!(cmd_valid && cmd_ready));
    code = cmd_code; bank = cmd_bank; row = cmd_row; col = cmd_col;
  endtask

  task automatic flush_all();
    int code, b, r, c;
    @(negedge clk); pa_req = 1'b1;
    @(negedge clk); pa_req = 1'b0;
    take_cmd(code, b, r, c);
    chk(code == 4, "R8", "precharge-all code", code, 4);
    @(negedge clk); cmd_ready = 1'b0;
    chk(!cmd_valid, "R8", "single precharge-all", cmd_valid, 0);
    foreach (m_vld[i]) m_vld[i] = 0;
  endtask

  task automatic access(longint addr, bit wr, bit scramble, string ftag);
    longint w, cc, bb, rr;
    int b, r, c, n, code, ab, ar, acol;
    int ec[3];
    bit others;
    w  = (addr & 64'hFFFF_FFFF) / 4;
    cc = longint'(1) << (8 + c_cb);
    bb = longint'(1) << c_bs;
    rr = longint'(1) << (11 + c_rb);
    c = int'(w % cc);
    if (c_md == 0) begin b = int'((w / cc) % bb); r = int'((w / (cc * bb)) % rr); end
    else           begin r = int'((w / cc) % rr); b = int'((w / (cc * rr)) % bb); end
    others = 0;
    foreach (m_vld[i]) if (m_vld[i] && i != b) others = 1;
    n = 0;
    if (m_vld[b] && m_row[b] == r && !(c_md == 1 && others)) begin
      ec[0] = wr ? 2 : 1; n = 1;
    end else if (c_md == 1 && (others || m_vld[b])) begin
      ec[0] = 4; ec[1] = 0; ec[2] = wr ? 2 : 1; n = 3;
      foreach (m_vld[i]) m_vld[i] = 0;
    end else if (c_md == 0 && m_vld[b]) begin
      ec[0] = 3; ec[1] = 0; ec[2] = wr ? 2 : 1; n = 3;
    end else begin
      ec[0] = 0; ec[1] = wr ? 2 : 1; n = 2;
    end
    m_vld[b] = 1; m_row[b] = r;

    @(negedge clk);
    req_addr = addr[31:0]; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (scramble) begin
      cfg_mode = ~cfg_mode; cfg_col_bits = ~cfg_col_bits;
      cfg_bank_sel = ~cfg_bank_sel; cfg_row_bits = cfg_row_bits + 2'd1;
    end
    for (int k = 0; k < n; k++) begin
      string stag;
      take_cmd(code, ab, ar, acol);
      stag = (n == 1) ? "R6" : (ec[0] == 3) ? "R5" : (ec[0] == 4) ? "R7" : "R4";
      chk(code == ec[k], stag, "command code", code, ec[k]);
      if (code == 3 || code == 0 || code == 1 || code == 2)
        chk(ab == b, ftag, "bank", ab, b);
      if (code == 0) chk(ar == r, ftag, "row", ar, r);
      if (code == 1 || code == 2) chk(acol == c, ftag, "column", acol, c);
    end
    @(negedge clk); cmd_ready = 1'b0;
    chk(!cmd_valid, "R9", "no command after read/write", cmd_valid, 0);
    chk(req_ready, "R9", "ready after sequence", req_ready, 1);
    if (scramble) apply_cfg(c_md, c_cb, c_bs, c_rb);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    longint a0, cap;
    foreach (m_vld[i]) begin m_vld[i] = 0; m_row[i] = 0; end
    apply_cfg(0, 0, 2, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R11", "req_ready after reset", req_ready, 1);
    chk(!cmd_valid, "R11", "cmd_valid after reset", cmd_valid, 0);
    access(32'h0000_1234, 1'b0, 1'b0, "R11");

    for (int md = 0; md < 2; md++)
      for (int cb = 0; cb < 4; cb++)
        for (int bs = 0; bs < 4; bs++)
          for (int rb = 0; rb < 3; rb++) begin
            string ft;
            ft = (md == 0) ? "R1" : "R2";
            apply_cfg(md, cb, bs, rb);
            flush_all();
            cap = (longint'(1) << (8 + cb + bs + 11 + rb)) * 4;
            a0 = longint'($urandom);
            access(a0, 1'b0, 1'b0, ft);
            access(a0 + 4, 1'b1, 1'b0, ft);
            access(a0 + (longint'(4) << (8 + cb)), 1'b0, 1'b0, ft);
            access((a0 + cap) & 64'hFFFF_FFFF, 1'b1, 1'b0, "R3");
            access(a0 + 3, 1'b0, 1'b0, ft);
            access(longint'($urandom), 1'b1, 1'b1, "R10");
            access(a0, 1'b0, 1'b1, "R10");
          end

    apply_cfg(0, 0, 2, 0);
    flush_all();
    access(32'h0000_0000, 1'b0, 1'b0, "R1");
    access(32'h0000_0400, 1'b0, 1'b0, "R1");
    apply_cfg(1, 0, 2, 0);
    access(32'h0000_0000, 1'b1, 1'b0, "R7");
    access(32'h0000_0010, 1'b0, 1'b0, "R6");
    flush_all();
    access(32'h0000_0010, 1'b0, 1'b0, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule